// File: doc/BRIEF.md
# Linear-to-Rectangle Copy Splitter

This block turns a flat byte-copy request (source offset, destination offset, byte count) into rectangle descriptors for a 2D copy engine that cannot move a linear range directly. It treats the range as a rectangle at one byte per pixel whose row width equals its row pitch. It picks the widest dword-aligned row that fits the engine's pitch field and enough full rows to cover most of the range. Any bytes left over go into a second descriptor, a single row that starts where the rectangle ends.

A request is accepted in one handshake. The row count comes from a bit-serial divider, so the block stays busy for a fixed number of cycles before the first descriptor appears. Descriptors leave on a valid/ready stream, at most two per request, the rectangle first and then the leftover row. A zero-length request is consumed without producing anything.

Top module: `lin2rect_split`

## Requirements
- R1: The rectangle descriptor's pitch is min(size, 2^PITCH_W-1) rounded down to a multiple of 4, and its width equals its pitch.
- R2: The rectangle's height is floor(size / pitch). When that pitch is 0 (size below 4), no rectangle descriptor is emitted and the whole size becomes the leftover.
- R3: The rectangle descriptor carries the request's source and destination offsets unchanged.
- R4: With leftover r = size - pitch*height non-zero, a tail descriptor follows with width r, height 1, pitch r rounded up to a multiple of 4, and both offsets advanced by pitch*height (modulo 2^OFS_W).
- R5: Descriptors leave in order, rectangle then tail, and no tail is emitted when r is 0. No descriptor has width 0.
- R6: A request with size 0 is accepted and produces no descriptor. busy stays low and req_ready stays high.
- R7: While d_valid is high and d_ready is low, every descriptor field holds its value. req_ready is low whenever busy is high.
- R8: The rectangle descriptor becomes valid SIZE_W+1 rising edges after the edge that accepts the request. A tail-only request (size 1 to 3) presents its tail right after the accepting edge.
- R9: busy rises on the accepting edge of a non-zero request and falls on the edge where the last descriptor is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Copy request offered |
| req_ready | output | 1 | Request can be taken (block idle) |
| req_src | input | OFS_W | Source byte offset |
| req_dst | input | OFS_W | Destination byte offset |
| req_size | input | SIZE_W | Byte count |
| d_valid | output | 1 | Descriptor valid |
| d_ready | input | 1 | Descriptor taken by consumer |
| d_pitch | output | PITCH_W | Row pitch in bytes, both surfaces |
| d_width | output | PITCH_W | Row width in bytes |
| d_height | output | SIZE_W | Number of rows |
| d_src | output | OFS_W | Source byte offset of the rectangle |
| d_dst | output | OFS_W | Destination byte offset of the rectangle |
| busy | output | 1 | A request is being split or emitted |

## Verification
The rectangle descriptor is due SIZE_W+1 edges after the accepting edge, the time the serial divider needs. A tail-only request presents its tail straight after that edge, and each later descriptor appears on the edge after the previous one is taken. The bench counts edges from acceptance to the first falling edge at which d_valid is seen and compares the count with those figures. It checks busy at the first falling edge after acceptance and again after the last transfer. All descriptor contents are sampled on falling edges where valid and ready are both high, and compared in order against a queue of expected descriptors. A second phase toggles d_ready pseudo-randomly and checks that stalled descriptors hold every field.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIV  = 2'd1,
      ST_BODY = 2'd2,
      ST_TAIL = 2'd3
   } lrs_state_e;
endpackage

// File: rtl/lrs_pitch.sv
module lrs_pitch #(
   parameter int SIZE_W  = 32,
   parameter int PITCH_W = 15
) (
   input  logic [SIZE_W-1:0]  size,
   output logic [PITCH_W-1:0] pitch
);
   localparam logic [PITCH_W-1:0] CAP = {PITCH_W{1'b1}};
   logic [PITCH_W-1:0] clamped;

   generate
      if (SIZE_W > PITCH_W) begin : g_clamp
         always_comb clamped = (size > SIZE_W'(CAP)) ? CAP : size[PITCH_W-1:0];
      end else begin : g_direct
         always_comb clamped = PITCH_W'(size);
      end
   endgenerate

   always_comb pitch = {clamped[PITCH_W-1:2], 2'b00};
endmodule

// File: rtl/lrs_divider.sv
module lrs_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quotient,
   output logic [W-1:0] remainder
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q, quo_q, div_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    trial;
   logic          fits;

   always_comb begin
      trial = {rem_q, quo_q[W-1]};
      fits  = trial >= {1'b0, div_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         div_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         rem_q <= '0;
         quo_q <= dividend;
         div_q <= divisor;
         cnt_q <= CW'(W);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q != '0) begin
            rem_q <= fits ? W'(trial - {1'b0, div_q}) : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
         end else begin
            run_q <= 1'b0;
         end
      end
   end

   assign done      = run_q && (cnt_q == '0);
   assign quotient  = quo_q;
   assign remainder = rem_q;

   // R2: a finished division leaves a remainder below the divisor
   p_rem_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (remainder < div_q));
endmodule

// File: rtl/lin2rect_split.sv
module lin2rect_split
   import lrs_pkg::*;
#(
   parameter int SIZE_W  = 32,
   parameter int OFS_W   = 32,
   parameter int PITCH_W = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [OFS_W-1:0]   req_src,
   input  logic [OFS_W-1:0]   req_dst,
   input  logic [SIZE_W-1:0]  req_size,
   output logic               d_valid,
   input  logic               d_ready,
   output logic [PITCH_W-1:0] d_pitch,
   output logic [PITCH_W-1:0] d_width,
   output logic [SIZE_W-1:0]  d_height,
   output logic [OFS_W-1:0]   d_src,
   output logic [OFS_W-1:0]   d_dst,
   output logic               busy
);
   generate
      if (PITCH_W < 3) begin : g_bad_pitch
         $error("PITCH_W must be at least 3");
      end
      if (SIZE_W < PITCH_W) begin : g_bad_size
         $error("SIZE_W must be at least PITCH_W");
      end
      if (OFS_W < SIZE_W) begin : g_bad_ofs
         $error("OFS_W must be at least SIZE_W");
      end
   endgenerate

   lrs_state_e         state_q;
   logic [OFS_W-1:0]   src_q, dst_q;
   logic [SIZE_W-1:0]  size_q, quo_q, rem_q;
   logic [PITCH_W-1:0] pitch_q, new_pitch, tail_pitch;
   logic [SIZE_W-1:0]  div_quo, div_rem, advance;
   logic               div_start, div_done, accept;

   lrs_pitch #(.SIZE_W(SIZE_W), .PITCH_W(PITCH_W)) u_pitch (
      .size  (req_size),
      .pitch (new_pitch)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready && (req_size != '0);
   assign div_start = accept && (new_pitch != '0);

   lrs_divider #(.W(SIZE_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (div_start),
      .dividend  (req_size),
      .divisor   (SIZE_W'(new_pitch)),
      .done      (div_done),
      .quotient  (div_quo),
      .remainder (div_rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         size_q  <= '0;
         quo_q   <= '0;
         rem_q   <= '0;
         pitch_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               src_q   <= req_src;
               dst_q   <= req_dst;
               size_q  <= req_size;
               pitch_q <= new_pitch;
               if (new_pitch == '0) begin
                  quo_q   <= SIZE_W'(1);
                  rem_q   <= req_size;
                  state_q <= ST_TAIL;
               end else begin
                  state_q <= ST_DIV;
               end
            end
            ST_DIV: if (div_done) begin
               quo_q   <= div_quo;
               rem_q   <= div_rem;
               state_q <= ST_BODY;
            end
            ST_BODY: if (d_ready) begin
               state_q <= (rem_q != '0) ? ST_TAIL : ST_IDLE;
            end
            default: if (d_ready) begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   always_comb begin
      advance    = size_q - rem_q;
      tail_pitch = PITCH_W'(rem_q) + PITCH_W'(3);
      tail_pitch = {tail_pitch[PITCH_W-1:2], 2'b00};
   end

   always_comb begin
      d_valid  = (state_q == ST_BODY) || (state_q == ST_TAIL);
      d_pitch  = pitch_q;
      d_width  = pitch_q;
      d_height = quo_q;
      d_src    = src_q;
      d_dst    = dst_q;
      if (state_q == ST_TAIL) begin
         d_pitch  = tail_pitch;
         d_width  = PITCH_W'(rem_q);
         d_height = SIZE_W'(1);
         d_src    = src_q + OFS_W'(advance);
         d_dst    = dst_q + OFS_W'(advance);
      end
   end

   assign busy = (state_q != ST_IDLE);

   // R1: rectangle rows are pitch-wide and dword aligned
   p_body_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BODY) |-> (d_pitch == d_width && d_pitch[1:0] == 2'b00));

   // R4: tail is one row, padded up to the next dword by less than 4
   p_tail_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TAIL) |-> (d_height == SIZE_W'(1) && d_pitch[1:0] == 2'b00 &&
                                d_pitch >= d_width && (d_pitch - d_width) < PITCH_W'(4)));

   // R5: no empty descriptor leaves the block
   p_no_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (d_width != '0 && d_height != '0));

   // R7: a stalled descriptor holds every field
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_ready) |=> (d_valid && $stable(d_pitch) && $stable(d_width) &&
                                 $stable(d_height) && $stable(d_src) && $stable(d_dst)));

   // R6: a zero-length request leaves the block idle
   p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_size == '0) |=> !busy);

   // R9: busy only starts from an accepted request
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid && req_ready && req_size != '0));
endmodule

// File: tb/sim_lin2rect_split.sv
module sim_lin2rect_split;
   localparam int SW = 32;
   localparam int OW = 32;
   localparam int PW = 15;
   localparam int CAP = (1 << PW) - 1;

   typedef struct {
      logic [PW-1:0] pitch;
      logic [PW-1:0] width;
      logic [SW-1:0] height;
      logic [OW-1:0] src;
      logic [OW-1:0] dst;
      bit            tail;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [OW-1:0] req_src = '0, req_dst = '0;
   logic [SW-1:0] req_size = '0;
   logic d_ready = 1'b1;
   logic req_ready, d_valid, busy;
   logic [PW-1:0] d_pitch, d_width;
   logic [SW-1:0] d_height;
   logic [OW-1:0] d_src, d_dst;

   int n_run = 0, n_fail = 0;
   bit stall_mode = 1'b0;
   bit finished = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   lin2rect_split #(.SIZE_W(SW), .OFS_W(OW), .PITCH_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_src(req_src), .req_dst(req_dst), .req_size(req_size),
      .d_valid(d_valid), .d_ready(d_ready), .d_pitch(d_pitch), .d_width(d_width),
      .d_height(d_height), .d_src(d_src), .d_dst(d_dst), .busy(busy)
   );

   task automatic chk(bit ok, string req, string msg);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   // consumer ready pattern
   initial forever begin
      @(posedge clk);
      #1 d_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
   end

   // monitor: compare transfers and stalled holds
   logic [PW-1:0] h_pitch, h_width;
   logic [SW-1:0] h_height;
   logic [OW-1:0] h_src, h_dst;
   bit was_stalled = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (was_stalled)
            chk(d_valid && d_pitch == h_pitch && d_width == h_width && d_height == h_height &&
                d_src == h_src && d_dst == h_dst, "R7",
                $sformatf("stall hold: got p%0d w%0d h%0d expected p%0d w%0d h%0d",
                          d_pitch, d_width, d_height, h_pitch, h_width, h_height));
         was_stalled = d_valid && !d_ready;
         h_pitch = d_pitch; h_width = d_width; h_height = d_height;
         h_src = d_src; h_dst = d_dst;
         if (d_valid && d_ready) begin
            if (q.size() == 0) begin
               chk(1'b0, "R5", $sformatf("unexpected descriptor w%0d, expected none", d_width));
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(d_pitch == e.pitch && d_width == e.width && d_height == e.height &&
                   d_src == e.src && d_dst == e.dst, e.tail ? "R4" : "R1 R2 R3",
                   $sformatf("got p%0d w%0d h%0d s%h d%h expected p%0d w%0d h%0d s%h d%h",
                             d_pitch, d_width, d_height, d_src, d_dst,
                             e.pitch, e.width, e.height, e.src, e.dst));
            end
         end
      end
   end

   task automatic drain();
      while (q.size() != 0) @(posedge clk);
      @(negedge clk);
      chk(!busy && req_ready, "R9", $sformatf("busy after last transfer: got %0b expected 0", busy));
   endtask

   task automatic send(logic [OW-1:0] s, logic [OW-1:0] d, logic [SW-1:0] n, bit lat);
      longint p, h, r;
      exp_t e;
      int cnt;
      p = (n > CAP) ? CAP : n;
      p = p & ~64'd3;
      if (p == 0) begin h = 1; r = n; end
      else begin h = n / p; r = n - p * h; end
      if (p != 0) begin
         e.pitch = PW'(p); e.width = PW'(p); e.height = SW'(h);
         e.src = s; e.dst = d; e.tail = 1'b0;
         q.push_back(e);
      end
      if (r != 0) begin
         e.pitch = PW'((r + 3) & ~64'd3); e.width = PW'(r); e.height = 1;
         e.src = s + OW'(p * h); e.dst = d + OW'(p * h); e.tail = 1'b1;
         q.push_back(e);
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_src = s; req_dst = d; req_size = n;
      @(posedge clk);
      #1 req_valid = 1'b0;
      if (lat) begin
         cnt = 0;
         @(negedge clk);
         chk(busy == (n != 0), "R9", $sformatf("busy after accept: got %0b expected %0b", busy, n != 0));
         while (!d_valid && cnt < 200) begin
            @(negedge clk);
            cnt++;
         end
         chk(cnt == ((p == 0) ? 0 : SW + 1), "R8",
             $sformatf("latency size %0d: got %0d expected %0d", n, cnt, (p == 0) ? 0 : SW + 1));
      end
      drain();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !d_valid && req_ready, "R7", $sformatf("reset state: busy %0b valid %0b ready %0b expected 0 0 1",
                                                          busy, d_valid, req_ready));
      // R6: zero size
      @(negedge clk);
      req_valid = 1'b1; req_size = '0; req_src = 32'h100; req_dst = 32'h200;
      @(posedge clk);
      #1 req_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!busy && !d_valid && req_ready, "R6",
             $sformatf("zero size cycle %0d: busy %0b valid %0b expected 0 0", i, busy, d_valid));
      end
      send(32'h1000, 32'h8000, 1, 1'b1);
      send(32'h1000, 32'h8000, 3, 1'b1);
      send(32'h10,   32'h20,   4, 1'b1);
      send(32'h0,    32'h400,  100, 1'b1);
      send(32'h3,    32'h7,    102, 1'b0);
      send(32'hA0,   32'hB0,   32767, 1'b1);
      send(32'hA0,   32'hB0,   32768, 1'b0);
      send(32'h4000, 32'h9000, 100000, 1'b0);
      send(32'h0,    32'h0,    32764 * 5, 1'b0);
      send(32'hFFFF_FFF0, 32'h10, 32'h0FFF_FFFF, 1'b1);
      stall_mode = 1'b1;
      send(32'h55, 32'h66, 70001, 1'b0);
      send(32'h1, 32'h2, 2, 1'b0);
      send(32'h100, 32'h900, 65535, 1'b0);
      send(32'h1234, 32'h5678, 40000, 1'b0);
      stall_mode = 1'b0;
      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule